// File: doc/BRIEF.md
# Host Request Address Router with High SMM Window

This block sorts every host-side memory request into one of three destinations: local DRAM, the downstream I/O link, or an invalid outcome that must be terminated. Requests come from either the processor or the I/O link. Each request carries an address that may be wider than the supported 36-bit physical space, an origin bit, an SMM-mode flag, a write-back attribute and a tag. The decision uses a handful of fixed windows near the 4 GB line and the DRAM top values that software programs: the low usable top, the top of memory, the reclaim enable and the reclaim limit.

One window, 128 KB wide at FEDA_0000h, can be switched on to act as a high alias of the legacy SMM segment. When it is on, SMM and write-back processor cycles land in DRAM at 000A_0000h..000B_FFFFh. Every other cycle that hits the window is refused. The DRAM that physically sits at the window address can never be reached. When the upper DRAM reclaim is on, the usable DRAM above 4 GB ends at the reclaim limit instead of the top of memory.

Each accepted request is classified in the same cycle and stored in one output register stage with a valid/ready handshake. The result holds the destination code, the address to forward, an abort flag and the tag the request arrived with.

Top module: `host_addr_router`

## Requirements
- R1: A request whose address has any bit set at or above bit 36 is given destination code 2 (invalid) with abort set, whatever its origin.
- R2: Any address in FEC0_0000h..FECF_FFFFh goes to the I/O link (code 1), even when the low usable DRAM top lies above it.
- R3: With the high SMM window enabled, a processor request in SMM mode to FEDA_0000h..FEDB_FFFFh goes to DRAM (code 0) at address 000A_0000h plus the low 17 address bits.
- R4: With the window enabled, a processor request outside SMM mode that is marked write-back is remapped exactly as in R3. One that is not marked write-back is invalid, with abort set.
- R5: With the window enabled, a request from the I/O link that hits the window is invalid with abort set, whatever its SMM and write-back flags.
- R6: With the window disabled, a request to FEDA_0000h..FEDB_FFFFh goes to the I/O link with its address unchanged, even when the low usable DRAM top lies above it.
- R7: Addresses FFE0_0000h..FFFF_FFFFh go to the I/O link.
- R8: Outside the fixed windows, an address below the low usable DRAM top goes to DRAM unchanged. An address from that top up to 4 GB goes to the I/O link.
- R9: From 4 GB upward, the upper DRAM top is the top of memory when reclaim is off and the reclaim limit when it is on. Addresses below that top go to DRAM, and addresses at or above it go to the I/O link.
- R10: The abort output is high exactly when the destination code is 2. For every non-remapped result, the forwarded address equals the low 36 request bits.
- R11: After reset no result is valid. Each accepted request yields exactly one result, in order, with its own tag. A result is held unchanged while rsp_ready is low, and req_ready is low while a held result is waiting.
- R12: No DRAM result ever carries an address inside FEDA_0000h..FEDB_FFFFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_addr | input | IN_AW (40) | Request address, may exceed the 36-bit space |
| req_from_link | input | 1 | 1 = request came up from the I/O link, 0 = processor |
| req_smm | input | 1 | Processor is in SMM mode |
| req_wb | input | 1 | Write-back or implicit write-back cycle |
| req_tag | input | TW (8) | Request tag, returned with the result |
| cfg_smm_hi_en | input | 1 | Enables the high SMM window |
| cfg_low_top | input | AW (36) | Top of low usable DRAM (exclusive) |
| cfg_mem_top | input | AW (36) | Top of populated memory, also the reclaim base |
| cfg_reclaim_en | input | 1 | Reclaim enable |
| cfg_reclaim_lim | input | AW (36) | Reclaim limit (exclusive) |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result taken |
| rsp_dest | output | 2 | 0 = DRAM, 1 = I/O link, 2 = invalid |
| rsp_addr | output | AW (36) | Address to forward |
| rsp_abort | output | 1 | Terminate the request |
| rsp_tag | output | TW (8) | Tag of the request this result belongs to |

## Verification
The bench builds the router with its default parameters: 36 address bits, a 40-bit request address and 8-bit tags. The four spare request bits let the bench drive addresses past the 36-bit space, which exercises the invalid range check. The 36-bit space itself reaches above 8 GB, so the window edges, the low DRAM top, the 4 GB line and both upper tops can each be hit at their first and last byte. Those tops are the top of memory with reclaim off and the reclaim limit with it on. The bench holds rsp_ready low during one phase, which shows the result being held and the request side blocked.

// File: rtl/hadr_pkg.sv
package hadr_pkg;

  typedef enum logic [1:0] {
    DST_DRAM = 2'd0,
    DST_LINK = 2'd1,
    DST_BAD  = 2'd2
  } dest_e;

  // Fixed windows, as 64-bit constants narrowed where used
  localparam logic [63:0] SMM_HI_BASE  = 64'h0000_0000_FEDA_0000;
  localparam int          SMM_HI_LOG2  = 17;
  localparam logic [63:0] SMM_LO_BASE  = 64'h0000_0000_000A_0000;
  localparam logic [63:0] IOAPIC_BASE  = 64'h0000_0000_FEC0_0000;
  localparam int          IOAPIC_LOG2  = 20;
  localparam logic [63:0] BOOT_BASE    = 64'h0000_0000_FFE0_0000;
  localparam int          BOOT_LOG2    = 21;
  localparam logic [63:0] FOUR_GB      = 64'h0000_0001_0000_0000;

endpackage

// File: rtl/hadr_window.sv
module hadr_window #(
  parameter int          AW   = 36,
  parameter logic [63:0] BASE = 64'h0,
  parameter int          LOG2 = 16
) (
  input  logic [AW-LOG2-1:0] addr_hi,
  output logic               hit
);
  localparam logic [AW-1:0] BASE_V = AW'(BASE);

  always_comb begin
    hit = (addr_hi == BASE_V[AW-1:LOG2]);
  end
endmodule

// File: rtl/hadr_classify.sv
module hadr_classify
  import hadr_pkg::*;
#(
  parameter int AW    = 36,
  parameter int IN_AW = 40
) (
  input  logic [IN_AW-1:0] addr,
  input  logic             from_link,
  input  logic             smm,
  input  logic             wb,
  input  logic             smm_hi_en,
  input  logic [AW-1:0]    low_top,
  input  logic [AW-1:0]    mem_top,
  input  logic             reclaim_en,
  input  logic [AW-1:0]    reclaim_lim,
  output dest_e            dest,
  output logic [AW-1:0]    out_addr,
  output logic             abort
);
  localparam logic [AW-1:0] FOUR_GB_V = AW'(FOUR_GB);
  localparam logic [AW-1:0] SMM_LO_V  = AW'(SMM_LO_BASE);

  logic [AW-1:0] low;
  logic          over;
  logic          hit_smm_hi;
  logic          hit_ioapic;
  logic          hit_boot;
  logic [AW-1:0] upper_top;

  assign low = addr[AW-1:0];

  generate
    if (IN_AW > AW) begin : g_wide
      assign over = |addr[IN_AW-1:AW];
    end else begin : g_exact
      assign over = 1'b0;
    end
  endgenerate

  hadr_window #(.AW(AW), .BASE(SMM_HI_BASE), .LOG2(SMM_HI_LOG2)) u_win_smm (
    .addr_hi(low[AW-1:SMM_HI_LOG2]), .hit(hit_smm_hi));
  hadr_window #(.AW(AW), .BASE(IOAPIC_BASE), .LOG2(IOAPIC_LOG2)) u_win_ioapic (
    .addr_hi(low[AW-1:IOAPIC_LOG2]), .hit(hit_ioapic));
  hadr_window #(.AW(AW), .BASE(BOOT_BASE), .LOG2(BOOT_LOG2)) u_win_boot (
    .addr_hi(low[AW-1:BOOT_LOG2]), .hit(hit_boot));

  assign upper_top = reclaim_en ? reclaim_lim : mem_top;

  always_comb begin
    dest     = DST_LINK;
    out_addr = low;
    abort    = 1'b0;
    if (over) begin
      dest  = DST_BAD;
      abort = 1'b1;
    end else if (hit_smm_hi) begin
      if (!smm_hi_en) begin
        dest = DST_LINK;
      end else if (from_link) begin
        dest  = DST_BAD;
        abort = 1'b1;
      end else if (smm || wb) begin
        dest     = DST_DRAM;
        out_addr = {SMM_LO_V[AW-1:SMM_HI_LOG2], low[SMM_HI_LOG2-1:0]};
      end else begin
        dest  = DST_BAD;
        abort = 1'b1;
      end
    end else if (hit_ioapic || hit_boot) begin
      dest = DST_LINK;
    end else if (low < low_top) begin
      dest = DST_DRAM;
    end else if (low < FOUR_GB_V) begin
      dest = DST_LINK;
    end else if (low < upper_top) begin
      dest = DST_DRAM;
    end else begin
      dest = DST_LINK;
    end
  end
endmodule

// File: rtl/hadr_pipe.sv
module hadr_pipe #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         v_q, v_d;
  logic         load;
  logic [W-1:0] d_q;

  always_comb begin
    in_ready = !v_q || out_ready;
    load     = in_valid && in_ready;
    v_d      = v_q;
    if (load)           v_d = 1'b1;
    else if (out_ready) v_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_d;
  end

  always_ff @(posedge clk) begin
    if (load) d_q <= in_data;
  end

  assign out_valid = v_q;
  assign out_data  = d_q;
endmodule

// File: rtl/host_addr_router.sv
module host_addr_router
  import hadr_pkg::*;
#(
  parameter int AW    = 36,
  parameter int IN_AW = 40,
  parameter int TW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [IN_AW-1:0] req_addr,
  input  logic             req_from_link,
  input  logic             req_smm,
  input  logic             req_wb,
  input  logic [TW-1:0]    req_tag,
  input  logic             cfg_smm_hi_en,
  input  logic [AW-1:0]    cfg_low_top,
  input  logic [AW-1:0]    cfg_mem_top,
  input  logic             cfg_reclaim_en,
  input  logic [AW-1:0]    cfg_reclaim_lim,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [1:0]       rsp_dest,
  output logic [AW-1:0]    rsp_addr,
  output logic             rsp_abort,
  output logic [TW-1:0]    rsp_tag
);
  localparam int PW = 2 + AW + 1 + TW;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  dest_e         c_dest;
  logic [AW-1:0] c_addr;
  logic          c_abort;
  logic [PW-1:0] p_in, p_out;

  hadr_classify #(.AW(AW), .IN_AW(IN_AW)) u_classify (
    .addr        (req_addr),
    .from_link   (req_from_link),
    .smm         (req_smm),
    .wb          (req_wb),
    .smm_hi_en   (cfg_smm_hi_en),
    .low_top     (cfg_low_top),
    .mem_top     (cfg_mem_top),
    .reclaim_en  (cfg_reclaim_en),
    .reclaim_lim (cfg_reclaim_lim),
    .dest        (c_dest),
    .out_addr    (c_addr),
    .abort       (c_abort)
  );

  assign p_in = {c_dest, c_addr, c_abort, req_tag};

  hadr_pipe #(.W(PW)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (p_in),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (p_out)
  );

  assign {rsp_dest, rsp_addr, rsp_abort, rsp_tag} = p_out;
endmodule

// File: rtl/hadr_checker.sv
module hadr_checker #(
  parameter int AW    = 36,
  parameter int IN_AW = 40,
  parameter int TW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [IN_AW-1:0] req_addr,
  input logic             req_from_link,
  input logic             cfg_smm_hi_en,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [1:0]       rsp_dest,
  input logic [AW-1:0]    rsp_addr,
  input logic             rsp_abort,
  input logic [TW-1:0]    rsp_tag
);
  logic accept;
  logic req_in_win;
  logic req_over;
  logic rsp_in_win;

  assign accept     = req_valid && req_ready;
  assign req_in_win = (req_addr >= IN_AW'(64'hFEDA_0000)) && (req_addr < IN_AW'(64'hFEDC_0000));
  assign req_over   = (req_addr >> AW) != '0;
  assign rsp_in_win = (rsp_addr >= AW'(64'hFEDA_0000)) && (rsp_addr < AW'(64'hFEDC_0000));

  p_abort_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_abort == (rsp_dest == 2'd2)));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_tag) && $stable(rsp_addr) && $stable(rsp_dest)));

  p_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_no_hidden_dram_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_dest == 2'd0) |-> !rsp_in_win);

  p_link_refused_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_from_link && cfg_smm_hi_en && req_in_win) |=> (rsp_valid && rsp_dest == 2'd2));

  p_over_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_over) |=> (rsp_valid && rsp_dest == 2'd2 && rsp_abort));
endmodule

bind host_addr_router hadr_checker #(.AW(AW), .IN_AW(IN_AW), .TW(TW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_addr      (req_addr),
  .req_from_link (req_from_link),
  .cfg_smm_hi_en (cfg_smm_hi_en),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_dest      (rsp_dest),
  .rsp_addr      (rsp_addr),
  .rsp_abort     (rsp_abort),
  .rsp_tag       (rsp_tag)
);

// File: tb/host_addr_router_tb.sv
`timescale 1ns/1ps
module host_addr_router_tb;
  localparam int AW    = 36;
  localparam int IN_AW = 40;
  localparam int TW    = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [IN_AW-1:0] req_addr = '0;
  logic             req_from_link = 1'b0;
  logic             req_smm = 1'b0;
  logic             req_wb = 1'b0;
  logic [TW-1:0]    req_tag = '0;
  logic             cfg_smm_hi_en = 1'b0;
  logic [AW-1:0]    cfg_low_top = '0;
  logic [AW-1:0]    cfg_mem_top = '0;
  logic             cfg_reclaim_en = 1'b0;
  logic [AW-1:0]    cfg_reclaim_lim = '0;
  logic             rsp_valid;
  logic             rsp_ready = 1'b1;
  logic [1:0]       rsp_dest;
  logic [AW-1:0]    rsp_addr;
  logic             rsp_abort;
  logic [TW-1:0]    rsp_tag;

  always #4 clk = ~clk;

  host_addr_router #(.AW(AW), .IN_AW(IN_AW), .TW(TW)) u_dut (.*);

  typedef struct packed {
    logic [TW-1:0] tag;
    logic [1:0]    dest;
    logic [AW-1:0] addr;
    logic          abort;
    logic [7:0]    req_id;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail = 0;
  logic [TW-1:0] tag_ctr = '0;
  bit   done = 1'b0;

  // expected outcome worked out from the requirements
  function automatic exp_t model(input logic [IN_AW-1:0] a, input logic lnk,
                                 input logic smm, input logic wb, input logic [7:0] rid);
    exp_t e;
    logic [AW-1:0] lo;
    logic [AW-1:0] top;
    lo = a[AW-1:0];
    top = cfg_reclaim_en ? cfg_reclaim_lim : cfg_mem_top;
    e.tag = tag_ctr; e.addr = lo; e.abort = 1'b0; e.dest = 2'd1; e.req_id = rid;
    if (a[IN_AW-1:AW] != '0) begin
      e.dest = 2'd2; e.abort = 1'b1;
    end else if (lo >= 36'hFEDA_0000 && lo <= 36'hFEDB_FFFF) begin
      if (!cfg_smm_hi_en) e.dest = 2'd1;
      else if (lnk) begin e.dest = 2'd2; e.abort = 1'b1; end
      else if (smm || wb) begin e.dest = 2'd0; e.addr = 36'hA_0000 + {19'd0, lo[16:0]}; end
      else begin e.dest = 2'd2; e.abort = 1'b1; end
    end else if (lo >= 36'hFEC0_0000 && lo <= 36'hFECF_FFFF) e.dest = 2'd1;
    else if (lo >= 36'hFFE0_0000 && lo <= 36'hFFFF_FFFF) e.dest = 2'd1;
    else if (lo < cfg_low_top) e.dest = 2'd0;
    else if (lo < 36'h1_0000_0000) e.dest = 2'd1;
    else if (lo < top) e.dest = 2'd0;
    else e.dest = 2'd1;
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // driver: called at a falling edge, returns at a falling edge
  task automatic send(input logic [IN_AW-1:0] a, input logic lnk, input logic smm,
                      input logic wb, input logic [7:0] rid);
    req_addr = a; req_from_link = lnk; req_smm = smm; req_wb = wb; req_tag = tag_ctr;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    exp_q.push_back(model(a, lnk, smm, wb, rid));
    @(negedge clk);
    req_valid = 1'b0;
    tag_ctr = tag_ctr + 1'b1;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11", "unexpected result", 64'(rsp_tag), 64'h0);
      end else begin
        exp_t e;
        string rq;
        e = exp_q.pop_front();
        rq = $sformatf("R%0d", e.req_id);
        check(rsp_tag == e.tag, "R11", "tag", 64'(rsp_tag), 64'(e.tag));
        check(rsp_dest == e.dest, rq, "dest", 64'(rsp_dest), 64'(e.dest));
        check(rsp_abort == e.abort, "R10", "abort", 64'(rsp_abort), 64'(e.abort));
        if (e.dest != 2'd2)
          check(rsp_addr == e.addr, rq, "addr", 64'(rsp_addr), 64'(e.addr));
        if (rsp_dest == 2'd0)
          check(!(rsp_addr >= 36'hFEDA_0000 && rsp_addr <= 36'hFEDB_FFFF), "R12",
                "dram addr in window", 64'(rsp_addr), 64'h0);
      end
    end
  end

  // watchdog
  initial begin
    #(8 * 200000);
    if (!done) begin
      check(1'b0, "WDOG", "timeout", 64'h0, 64'h1);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    cfg_low_top     = 36'h0_8000_0000;
    cfg_mem_top     = 36'h1_8000_0000;
    cfg_reclaim_lim = 36'h2_0000_0000;
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R11", "valid in reset", 64'(rsp_valid), 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(rsp_valid == 1'b0 && req_ready == 1'b1, "R11", "idle after reset",
          {62'h0, rsp_valid, req_ready}, 64'h1);

    // R8 low DRAM and hole
    send(40'h0_1234_5678, 0, 0, 0, 8);
    send(40'h0_7FFF_FFFF, 0, 0, 0, 8);
    send(40'h0_8000_0000, 0, 0, 0, 8);
    send(40'h0_FFDF_FFFF, 1, 0, 0, 8);
    // R7 boot region
    send(40'h0_FFE0_0000, 0, 0, 0, 7);
    send(40'h0_FFFF_FFFF, 1, 0, 0, 7);
    // R6 window disabled
    send(40'h0_FEDA_0000, 0, 1, 0, 6);
    // R2 IOAPIC
    send(40'h0_FEC0_0000, 1, 0, 0, 2);
    // R9 upper DRAM, reclaim off
    send(40'h1_0000_0000, 0, 0, 0, 9);
    send(40'h1_7FFF_FFFF, 0, 0, 0, 9);
    send(40'h1_8000_0000, 0, 0, 0, 9);
    send(40'hF_FFFF_FFFF, 0, 0, 0, 9);
    // R1 above 36 bits
    send(40'h10_0000_0000, 0, 0, 0, 1);
    send(40'h80_0000_1000, 1, 1, 1, 1);

    // low top raised above the windows
    cfg_low_top = 36'h0_FF00_0000;
    send(40'h0_FECF_FFFF, 0, 0, 0, 2);
    send(40'h0_FEDB_FFFF, 0, 0, 0, 6);
    send(40'h0_FEBF_FFFF, 0, 0, 0, 8);

    // R3 / R4 / R5 window enabled
    cfg_smm_hi_en = 1'b1;
    send(40'h0_FEDA_1234, 0, 1, 0, 3);
    send(40'h0_FEDB_FFFF, 0, 1, 0, 3);
    send(40'h0_FEDB_0010, 0, 0, 1, 4);
    send(40'h0_FEDA_0040, 0, 0, 0, 4);
    send(40'h0_FEDA_0080, 1, 1, 1, 5);
    send(40'h0_FEDB_8000, 1, 0, 0, 5);
    send(40'h0_FED9_FFFF, 0, 0, 0, 8);
    send(40'h0_FEDC_0000, 0, 0, 0, 8);

    // R9 reclaim on
    cfg_reclaim_en = 1'b1;
    send(40'h1_8000_0000, 0, 0, 0, 9);
    send(40'h1_FFFF_FFFF, 0, 0, 0, 9);
    send(40'h2_0000_0000, 0, 0, 0, 9);

    // R11 back-pressure
    @(posedge clk); #1 rsp_ready = 1'b0;
    @(negedge clk);
    send(40'h0_0000_4000, 0, 0, 0, 8);
    repeat (3) begin
      @(negedge clk);
      check(rsp_valid == 1'b1 && req_ready == 1'b0, "R11", "held while stalled",
            {62'h0, rsp_valid, req_ready}, 64'h2);
      check(rsp_tag == tag_ctr - 1'b1, "R11", "held tag", 64'(rsp_tag), 64'(tag_ctr - 1'b1));
    end
    @(posedge clk); #1 rsp_ready = 1'b1;
    @(negedge clk);
    send(40'h0_0000_8000, 0, 0, 0, 8);

    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, "R11", "results outstanding", 64'(exp_q.size()), 64'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule